// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does so by reading a two-level page table from memory in hardware. A requester presents the logical address, a read/write flag and the base address of the current process's outer table. It holds these inputs until the block answers with a one-cycle completion pulse. That pulse carries either the translated physical address or a two-bit fault code. A context switch needs nothing more than a different base value on the next request.

The walk reads the outer entry, then the inner entry, through a single-word memory port with a ready handshake. Both entries must be valid, and a write needs the page to be writable. On a successful access the block sets the referenced bit in the inner (last-level) entry, and on a write it also sets the dirty bit. It does this with one write-back to memory. The write-back is left out when the entry already holds the required bits.

Top module: `pgw_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: The first memory command of a request is a read of word address `base + 4 * vaddr[31:22]`.
- R3: After a valid outer entry, the second command reads `{outer_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: An outer entry with bit 0 (valid) clear ends the walk after that read, with fault code 01 and `paddr` 0.
- R5: An inner entry with bit 0 clear ends the walk with fault code 10, `paddr` 0 and no write-back.
- R6: A write request whose valid inner entry has bit 1 (writable) clear ends with fault code 11, `paddr` 0 and no write-back. A read of such a page succeeds.
- R7: A successful walk reports fault code 00 and `paddr = {inner_entry[31:12], vaddr[11:0]}`.
- R8: A successful access writes the inner entry back to its own address with bit 2 (referenced) set and all other bits unchanged, apart from R9.
- R9: A successful write request also sets bit 3 (dirty) in the written-back inner entry.
- R10: No write-back is issued when the inner entry already has bit 2 set, and also bit 3 set for a write request. Each request issues no memory command beyond those in R2, R3 and R8.
- R11: Only one of `mem_rd` and `mem_wr` is ever high. A command holds its address until `mem_ack`. `done` is a single-cycle pulse, given once per request.
- R12: The same logical address issued with a different base value is translated through the table that base selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_base | input | 32 | Physical address of the outer table |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Physical address, valid with `done` |
| fault | output | 2 | 00 none, 01 outer invalid, 10 inner invalid, 11 write to read-only |
| mem_rd | output | 1 | Word read command |
| mem_wr | output | 1 | Word write command |
| mem_addr | output | 32 | Byte address of the command |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the pending command this cycle |

## Verification
A wrong walk state shows up at once on the memory port. It appears as a command of the wrong kind, at the wrong address, or one command too many or too few. The bench compares every acknowledged command against a model queue in the same cycle. A corrupted latched entry or fault register becomes visible only in the `done` cycle, as a wrong `paddr` or fault code. A write-back with wrong bits changes the table for later requests, so the next translation of that page also shows it. Memory latency is varied from zero to two wait cycles to expose commands that drop before their acknowledge.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OUTER,
      ST_INNER,
      ST_UPDATE,
      ST_DONE
   } walk_st_t;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_OUTER = 2'b01,
      FLT_INNER = 2'b10,
      FLT_PROT  = 2'b11
   } flt_t;

   // entry flag positions
   localparam int BIT_VALID = 0;
   localparam int BIT_WRITE = 1;
   localparam int BIT_REF   = 2;
   localparam int BIT_DIRTY = 3;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFF_W = 12,
   parameter int IDX_W = 10
) (
   input  logic [VA_W-1:0]       vaddr,
   input  logic [PA_W-1:0]       base,
   input  logic [PA_W-OFF_W-1:0] outer_frame,
   input  logic [PA_W-OFF_W-1:0] leaf_frame,
   output logic [PA_W-1:0]       outer_addr,
   output logic [PA_W-1:0]       inner_addr,
   output logic [PA_W-1:0]       phys_addr
);
   localparam int OUT_W = VA_W - OFF_W - IDX_W;
   localparam int WORD_SH = 2;

   initial begin
      assert (OUT_W > 0 && OUT_W + WORD_SH <= PA_W)
         else $error("outer index width out of range");
      assert (IDX_W + WORD_SH <= OFF_W)
         else $error("inner table must fit in one frame");
   end

   logic [OUT_W-1:0] outer_idx;
   logic [IDX_W-1:0] inner_idx;

   assign outer_idx = vaddr[VA_W-1 -: OUT_W];
   assign inner_idx = vaddr[OFF_W +: IDX_W];

   assign outer_addr = base + (PA_W'(outer_idx) << WORD_SH);
   assign inner_addr = {outer_frame, {OFF_W{1'b0}}} | (PA_W'(inner_idx) << WORD_SH);
   assign phys_addr  = {leaf_frame, vaddr[OFF_W-1:0]};

endmodule

// File: rtl/pgw_pte_eval.sv
module pgw_pte_eval
   import pgw_pkg::*;
#(
   parameter int PTE_W         = 32,
   parameter bit SKIP_CLEAN_WB = 1'b1
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             is_write,
   output logic             valid,
   output logic             perm_bad,
   output logic [PTE_W-1:0] new_pte,
   output logic             need_wb
);
   initial begin
      assert (PTE_W > BIT_DIRTY) else $error("entry too narrow for flags");
   end

   logic [PTE_W-1:0] set_mask;

   always_comb begin
      set_mask            = '0;
      set_mask[BIT_REF]   = 1'b1;
      set_mask[BIT_DIRTY] = is_write;
   end

   assign valid    = pte[BIT_VALID];
   assign perm_bad = is_write & ~pte[BIT_WRITE];
   assign new_pte  = pte | set_mask;

   generate
      if (SKIP_CLEAN_WB) begin : g_skip_clean
         assign need_wb = (new_pte != pte);
      end else begin : g_always_wb
         assign need_wb = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int VA_W          = 32,
   parameter int PA_W          = 32,
   parameter int OFF_W         = 12,
   parameter int IDX_W         = 10,
   parameter bit SKIP_CLEAN_WB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   input  logic [PA_W-1:0] req_base,
   output logic            done,
   output logic [PA_W-1:0] paddr,
   output logic [1:0]      fault,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [PA_W-1:0] mem_addr,
   output logic [PA_W-1:0] mem_wdata,
   input  logic [PA_W-1:0] mem_rdata,
   input  logic            mem_ack
);
   localparam int FRM_W = PA_W - OFF_W;

   walk_st_t         state;
   logic [VA_W-1:0]  va_q;
   logic             wr_q;
   logic [PA_W-1:0]  base_q;
   logic [FRM_W-1:0] outer_frm_q;
   logic [PA_W-1:0]  wb_q;
   logic [PA_W-1:0]  paddr_q;
   flt_t             fault_q;

   logic [PA_W-1:0] outer_addr, inner_addr, phys_addr;
   logic            pte_valid, perm_bad, need_wb;
   logic [PA_W-1:0] new_pte;

   pgw_addr_gen #(
      .VA_W (VA_W),
      .PA_W (PA_W),
      .OFF_W(OFF_W),
      .IDX_W(IDX_W)
   ) u_addr (
      .vaddr      (va_q),
      .base       (base_q),
      .outer_frame(outer_frm_q),
      .leaf_frame (mem_rdata[PA_W-1:OFF_W]),
      .outer_addr (outer_addr),
      .inner_addr (inner_addr),
      .phys_addr  (phys_addr)
   );

   pgw_pte_eval #(
      .PTE_W        (PA_W),
      .SKIP_CLEAN_WB(SKIP_CLEAN_WB)
   ) u_eval (
      .pte     (mem_rdata),
      .is_write(wr_q),
      .valid   (pte_valid),
      .perm_bad(perm_bad),
      .new_pte (new_pte),
      .need_wb (need_wb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         va_q        <= '0;
         wr_q        <= 1'b0;
         base_q      <= '0;
         outer_frm_q <= '0;
         wb_q        <= '0;
         paddr_q     <= '0;
         fault_q     <= FLT_NONE;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  base_q  <= req_base;
                  paddr_q <= '0;
                  fault_q <= FLT_NONE;
                  state   <= ST_OUTER;
               end
            end
            ST_OUTER: begin
               if (mem_ack) begin
                  if (!pte_valid) begin
                     fault_q <= FLT_OUTER;
                     state   <= ST_DONE;
                  end else begin
                     outer_frm_q <= mem_rdata[PA_W-1:OFF_W];
                     state       <= ST_INNER;
                  end
               end
            end
            ST_INNER: begin
               if (mem_ack) begin
                  if (!pte_valid) begin
                     fault_q <= FLT_INNER;
                     state   <= ST_DONE;
                  end else if (perm_bad) begin
                     fault_q <= FLT_PROT;
                     state   <= ST_DONE;
                  end else begin
                     paddr_q <= phys_addr;
                     wb_q    <= new_pte;
                     state   <= need_wb ? ST_UPDATE : ST_DONE;
                  end
               end
            end
            ST_UPDATE: begin
               if (mem_ack) state <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd    = (state == ST_OUTER) || (state == ST_INNER);
   assign mem_wr    = (state == ST_UPDATE);
   assign mem_addr  = (state == ST_OUTER) ? outer_addr : inner_addr;
   assign mem_wdata = wb_q;
   assign done      = (state == ST_DONE);
   assign paddr     = paddr_q;
   assign fault     = fault_q;

   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr))); // R11
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault != 2'b00) |-> (paddr == '0)); // R4
   AST_WB_REF: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata[BIT_REF]); // R8
   AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && wr_q) |-> mem_wdata[BIT_DIRTY]); // R9
   AST_WB_AFTER_INNER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> $past(mem_rd && mem_ack)); // R10

endmodule

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_base = '0;
   logic        done;
   logic [31:0] paddr;
   logic [1:0]  fault;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   pgw_walker u_pgw_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_vaddr(req_vaddr),
      .req_write(req_write),
      .req_base (req_base),
      .done     (done),
      .paddr    (paddr),
      .fault    (fault),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .mem_ack  (mem_ack)
   );

   // kind: 0 outer read, 1 inner read, 2 write-back
   typedef struct packed {
      logic [1:0]  kind;
      logic        wreq;
      logic [31:0] addr;
      logic [31:0] data;
   } op_t;

   op_t         exp_q[$];
   logic [31:0] mem [logic [31:0]];
   int          errs = 0;
   int          checks = 0;
   int          lat = 0;
   int unsigned lfsr = 32'h1d2c3b4a;
   bit          busy = 0;
   bit          prev_done = 0;
   logic [1:0]  exp_fault;
   logic [31:0] exp_paddr;

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // memory responder with 0..2 wait cycles, compares each accepted command
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0;
         lat = 0;
      end else if (mem_rd || mem_wr) begin
         if (mem_rd && mem_wr) chk(1'b0, "R11", {mem_rd, mem_wr}, 0);
         if (lat == 0) begin
            op_t op;
            mem_ack = 1'b1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", mem_addr, 32'h0);
            end else begin
               op = exp_q.pop_front();
               chk(mem_wr == (op.kind == 2'd2), "R11", {31'h0, mem_wr}, {31'h0, op.kind == 2'd2});
               case (op.kind)
                  2'd0: chk(mem_addr == op.addr, "R2", mem_addr, op.addr);
                  2'd1: chk(mem_addr == op.addr, "R3", mem_addr, op.addr);
                  default: begin
                     chk(mem_addr == op.addr, "R8", mem_addr, op.addr);
                     if (op.wreq) chk(mem_wdata == op.data, "R9", mem_wdata, op.data);
                     else         chk(mem_wdata == op.data, "R8", mem_wdata, op.data);
                  end
               endcase
            end
            if (mem_rd) mem_rdata = rdm(mem_addr);
            else        mem[mem_addr] = mem_wdata;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lat = int'(lfsr % 3);
         end else begin
            mem_ack = 1'b0;
            lat--;
         end
      end else begin
         mem_ack = 1'b0;
      end
   end

   // done must be a single pulse and only while a request is open
   always @(negedge clk) begin
      if (rst_n && done && !busy) chk(1'b0, "R11", {31'h0, done}, 0);
      if (rst_n && done && prev_done) chk(1'b0, "R11", {31'h0, done}, 0);
      prev_done = done;
   end

   task automatic predict(input logic [31:0] va, input bit wr, input logic [31:0] base);
      logic [31:0] oa, ia, e1, e2, n;
      oa = base + {20'h0, va[31:22], 2'b00};
      exp_q.push_back('{2'd0, wr, oa, 32'h0});
      e1 = rdm(oa);
      exp_paddr = 32'h0;
      if (!e1[0]) begin
         exp_fault = 2'b01;
         return;
      end
      ia = {e1[31:12], va[21:12], 2'b00};
      exp_q.push_back('{2'd1, wr, ia, 32'h0});
      e2 = rdm(ia);
      if (!e2[0]) begin
         exp_fault = 2'b10;
      end else if (wr && !e2[1]) begin
         exp_fault = 2'b11;
      end else begin
         exp_fault = 2'b00;
         n = e2 | 32'h4 | (wr ? 32'h8 : 32'h0);
         if (n != e2) exp_q.push_back('{2'd2, wr, ia, n});
         exp_paddr = {e2[31:12], va[11:0]};
      end
   endtask

   task automatic run_req(input logic [31:0] va, input bit wr, input logic [31:0] base,
                          output logic [31:0] got_paddr);
      int cyc;
      predict(va, wr, base);
      @(negedge clk);
      req_vaddr = va;
      req_write = wr;
      req_base  = base;
      req_valid = 1'b1;
      busy      = 1'b1;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (done) break;
         if (cyc > 200) begin
            chk(1'b0, "R11", cyc, 200);
            finish_run();
         end
      end
      got_paddr = paddr;
      case (exp_fault)
         2'b01:   chk(fault == exp_fault, "R4", {30'h0, fault}, {30'h0, exp_fault});
         2'b10:   chk(fault == exp_fault, "R5", {30'h0, fault}, {30'h0, exp_fault});
         2'b11:   chk(fault == exp_fault, "R6", {30'h0, fault}, {30'h0, exp_fault});
         default: chk(fault == exp_fault, "R7", {30'h0, fault}, {30'h0, exp_fault});
      endcase
      chk(paddr == exp_paddr, "R7", paddr, exp_paddr);
      chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
      exp_q.delete();
      req_valid = 1'b0;
      @(negedge clk);
      busy = 1'b0;
   endtask

   localparam logic [31:0] BASE_A = 32'h0001_0000;
   localparam logic [31:0] BASE_B = 32'h0005_0000;

   initial begin
      logic [31:0] pa;
      // table A
      mem[32'h0001_0004] = 32'h0002_0001;
      mem[32'h0002_000C] = 32'h0ABC_D003;
      mem[32'h0002_0014] = 32'h0033_3001;
      mem[32'h0001_0FFC] = 32'h0003_0001;
      mem[32'h0003_0FFC] = 32'hFFFF_F00F;
      // table B
      mem[32'h0005_0004] = 32'h0006_0001;
      mem[32'h0006_000C] = 32'h0077_7003;

      repeat (3) @(negedge clk);
      chk(!done && !mem_rd && !mem_wr, "R1", {done, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_rd && !mem_wr, "R1", {done, mem_rd, mem_wr}, 0);

      run_req(32'h0040_3ABC, 1'b0, BASE_A, pa);  // R7 R8 first read sets ref
      run_req(32'h0040_3ABC, 1'b0, BASE_A, pa);  // R10 ref already set
      run_req(32'h0040_3ABC, 1'b1, BASE_A, pa);  // R9 write sets dirty
      run_req(32'h0040_3ABC, 1'b1, BASE_A, pa);  // R10 both already set
      run_req(32'h0080_0000, 1'b0, BASE_A, pa);  // R4 outer invalid
      run_req(32'h0000_0123, 1'b1, BASE_A, pa);  // R4 index zero
      run_req(32'h0040_7000, 1'b0, BASE_A, pa);  // R5 inner invalid
      run_req(32'h0040_5123, 1'b1, BASE_A, pa);  // R6 write to read-only
      run_req(32'h0040_5123, 1'b0, BASE_A, pa);  // R6 read of read-only works
      run_req(32'hFFFF_FFFF, 1'b0, BASE_A, pa);  // R2 R3 top indices, skip wb
      chk(pa == 32'hFFFF_FFFF, "R7", pa, 32'hFFFF_FFFF);
      run_req(32'hFFFF_FFFF, 1'b1, BASE_A, pa);  // R10
      run_req(32'h0040_3ABC, 1'b0, BASE_B, pa);  // R12 other table
      chk(pa == 32'h0077_7ABC, "R12", pa, 32'h0077_7ABC);
      run_req(32'h0040_3ABC, 1'b0, BASE_A, pa);  // R12 back to first table
      chk(pa == 32'h0ABC_DABC, "R12", pa, 32'h0ABC_DABC);

      for (int i = 0; i < 12; i++) begin
         logic [31:0] va;
         case (i % 4)
            0: va = 32'h0040_3000 | (i * 32'h11);
            1: va = 32'h0040_5000 | (i * 32'h21);
            2: va = 32'h0040_7FF0;
            default: va = 32'hFFFF_F000 | i;
         endcase
         run_req(va, i[0], (i % 3 == 0) ? BASE_B : BASE_A, pa);
      end

      finish_run();
   end

   initial begin
      #2_000_000;
      chk(1'b0, "R11", 0, 1);
      finish_run();
   end

endmodule